// File: doc/BRIEF.md
# Level and Pulse-Width Trigger Detector

This block watches a stream of 8-bit samples from one of two channels and raises a one-clock trigger strobe when a programmed condition is met. There are two plain threshold modes that fire when the sample crosses to above or to below a programmable level. Two duration-qualified modes fire only after the sample has stayed beyond the level for a programmed number of valid samples. A fifth mode passes through an external trigger from a protocol monitor. The block does no protocol decoding.

Software selects the mode, the channel, the level and the run length. It then raises `arm`. The strobe on `trig_out` starts the capture logic downstream. While `arm` is low the detector keeps tracking its inputs, but it emits no strobe.

Top module: `trig_detect`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `trig_out` is 0.
- R2: Mode code 0 (above) fires when a valid sample on the selected channel is greater than `level` and the previous valid sample was not. The strobe appears in the cycle after the clock edge that takes in the sample.
- R3: Mode code 1 (below) fires when a valid sample is less than `level` and the previous valid sample was not. It has the same one-edge latency as R2.
- R4: A sample equal to `level` satisfies neither the above condition nor the below condition. Unsigned comparison is used.
- R5: `chan_sel`=0 compares `smp_a` and `chan_sel`=1 compares `smp_b`. The other channel has no effect.
- R6: Mode code 2 (high pulse) fires once, on the valid sample that completes a run of `pulse_len` consecutive valid samples above `level`. It does not fire again while the run continues.
- R7: Mode code 3 (low pulse) behaves as R6, with samples below `level`.
- R8: A valid sample that fails the condition restarts the run count. Cycles with `smp_valid` low neither count nor restart the run. `pulse_len`=0 never fires.
- R9: Mode code 4 (external) fires on each rising edge of `ext_trig`, independent of `smp_valid`. In the other modes `ext_trig` has no effect.
- R10: `trig_out` is never high unless `arm` was high at the edge that produced it. Edge and run tracking continue while the detector is disarmed.
- R11: Mode codes 5, 6 and 7 never fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Enables the trigger strobe |
| mode | input | 3 | Trigger mode code (0 above, 1 below, 2 high pulse, 3 low pulse, 4 external) |
| chan_sel | input | 1 | Channel to compare: 0 selects A, 1 selects B |
| level | input | SW | Trigger threshold |
| pulse_len | input | CW | Run length in valid samples for the pulse modes |
| smp_valid | input | 1 | Sample strobe |
| smp_a | input | SW | Channel A sample |
| smp_b | input | SW | Channel B sample |
| ext_trig | input | 1 | External protocol trigger |
| trig_out | output | 1 | One-clock trigger strobe |

## Verification
The threshold modes are swept with a full up-and-down ramp across several levels, including 0 and 255. On these sweeps the unused channel carries the complement of the selected one, so a wrong channel choice or an off-by-one at equality shows as a misplaced strobe. The pulse modes get runs of lengths 1 to 7 with invalid gaps inside them, for several run lengths. These runs separate a counter that fires early, fires late, fires repeatedly or resets on a gap. Extra passes exercise external edges against sample strobes, the arm line toggling during a sweep, and the unused mode codes.

// File: rtl/trig_detect.sv
module trig_detect #(
  parameter int SW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [2:0]    mode,
  input  logic          chan_sel,
  input  logic [SW-1:0] level,
  input  logic [CW-1:0] pulse_len,
  input  logic          smp_valid,
  input  logic [SW-1:0] smp_a,
  input  logic [SW-1:0] smp_b,
  input  logic          ext_trig,
  output logic          trig_out
);
  localparam logic [2:0] M_ABOVE = 3'd0;
  localparam logic [2:0] M_BELOW = 3'd1;
  localparam logic [2:0] M_HIGHP = 3'd2;
  localparam logic [2:0] M_LOWP  = 3'd3;
  localparam logic [2:0] M_EXT   = 3'd4;

  logic [SW-1:0] smp;
  logic          cond, prev_cond, ext_q, run_more, fire;
  logic [CW-1:0] cnt;

  assign smp      = chan_sel ? smp_b : smp_a;
  assign run_more = cnt < pulse_len;

  always_comb begin
    case (mode)
      M_ABOVE, M_HIGHP: cond = smp > level;
      M_BELOW, M_LOWP:  cond = smp < level;
      default:          cond = 1'b0;
    endcase
  end

  always_comb begin
    case (mode)
      M_ABOVE, M_BELOW: fire = smp_valid && cond && !prev_cond;
      M_HIGHP, M_LOWP:  fire = smp_valid && cond && run_more && (cnt + CW'(1) == pulse_len);
      M_EXT:            fire = ext_trig && !ext_q;
      default:          fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_cond <= 1'b0;
      cnt       <= '0;
      ext_q     <= 1'b0;
      trig_out  <= 1'b0;
    end else begin
      ext_q    <= ext_trig;
      trig_out <= arm && fire;
      if (smp_valid) begin
        prev_cond <= cond;
        cnt       <= !cond ? '0 : (run_more ? cnt + CW'(1) : cnt);
      end
    end
  end
endmodule

module trig_detect_chk #(
  parameter int SW = 8,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm,
  input logic [2:0]    mode,
  input logic          chan_sel,
  input logic [SW-1:0] level,
  input logic          smp_valid,
  input logic [SW-1:0] smp_a,
  input logic [SW-1:0] smp_b,
  input logic          ext_trig,
  input logic          trig_out
);
  logic [SW-1:0] pick;
  assign pick = chan_sel ? smp_b : smp_a;

  a_r10_disarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> $past(arm));
  a_r2_above_cross: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out && $past(mode) == 3'd0) |-> ($past(smp_valid) && $past(pick) > $past(level)));
  a_r3_below_cross: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out && $past(mode) == 3'd1) |-> ($past(smp_valid) && $past(pick) < $past(level)));
  a_r9_ext_source: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out && $past(mode) == 3'd4) |-> $past(ext_trig));
  a_r11_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> $past(mode) <= 3'd4);
endmodule

bind trig_detect trig_detect_chk #(.SW(SW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .arm(arm), .mode(mode), .chan_sel(chan_sel),
  .level(level), .smp_valid(smp_valid), .smp_a(smp_a), .smp_b(smp_b),
  .ext_trig(ext_trig), .trig_out(trig_out));

// File: tb/trig_detect_tb.sv
module trig_detect_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic        chan_sel = 1'b0;
  logic [7:0]  level = 8'd0;
  logic [15:0] pulse_len = 16'd0;
  logic        smp_valid = 1'b0;
  logic [7:0]  smp_a = 8'd0;
  logic [7:0]  smp_b = 8'd0;
  logic        ext_trig = 1'b0;
  logic        trig_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  bit m_prev;
  int m_cnt;
  bit m_ext;

  trig_detect dut_i (
    .clk(clk), .rst_n(rst_n), .arm(arm), .mode(mode), .chan_sel(chan_sel),
    .level(level), .pulse_len(pulse_len), .smp_valid(smp_valid),
    .smp_a(smp_a), .smp_b(smp_b), .ext_trig(ext_trig), .trig_out(trig_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(bit got, bit exp, string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b (mode %0d lvl %0d a %0d b %0d)",
               tag, got, exp, mode, level, smp_a, smp_b);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smp_valid = 0; ext_trig = 0;
    @(posedge clk); #1 check(trig_out, 1'b0, "R1");
    @(negedge clk); rst_n = 1'b1;
    m_prev = 0; m_cnt = 0; m_ext = 0;
  endtask

  task automatic step(bit v, logic [7:0] a, logic [7:0] b, bit e, string tag);
    logic [7:0] s;
    bit cond, fire;
    @(negedge clk);
    smp_valid = v; smp_a = a; smp_b = b; ext_trig = e;
    s = chan_sel ? b : a;
    cond = (mode == 0 || mode == 2) ? (s > level) :
           (mode == 1 || mode == 3) ? (s < level) : 1'b0;
    fire = 0;
    if (mode <= 1) fire = v && cond && !m_prev;
    else if (mode <= 3) fire = v && cond && (m_cnt < pulse_len) && (m_cnt + 1 == pulse_len);
    else if (mode == 4) fire = e && !m_ext;
    m_ext = e;
    if (v) begin
      m_prev = cond;
      if (!cond) m_cnt = 0;
      else if (m_cnt < pulse_len) m_cnt++;
    end
    @(posedge clk); #1 check(trig_out, arm && fire, tag);
  endtask

  initial begin
    logic [7:0] lv [5] = '{8'd0, 8'd1, 8'd100, 8'd254, 8'd255};
    int lens [4] = '{0, 1, 2, 5};
    #1 check(trig_out, 1'b0, "R1");
    do_reset();
    check(trig_out, 1'b0, "R1");

    // Directed equality case
    arm = 1; mode = 0; level = 8'd100;
    step(1, 8'd100, 8'd0, 0, "R4");
    step(1, 8'd100, 8'd0, 0, "R4");
    step(1, 8'd101, 8'd0, 0, "R2");
    mode = 1;
    step(1, 8'd100, 8'd0, 0, "R4");
    step(1, 8'd99, 8'd0, 0, "R3");

    // Level ramps, both channels, other channel complemented
    for (int md = 0; md < 2; md++)
      for (int ch = 0; ch < 2; ch++)
        for (int li = 0; li < 5; li++) begin
          do_reset();
          arm = 1; mode = 3'(md); chan_sel = ch[0]; level = lv[li];
          for (int k = 0; k < 512; k++) begin
            logic [7:0] x;
            x = (k < 256) ? 8'(k) : 8'(511 - k);
            step(k % 3 != 2, ch ? ~x : x, ch ? x : ~x, k[4],
                 md == 0 ? (ch ? "R2/R5" : "R2") : (ch ? "R3/R5" : "R3"));
          end
        end

    // Pulse modes with runs and invalid gaps
    for (int md = 2; md < 4; md++)
      for (int li = 0; li < 4; li++) begin
        do_reset();
        arm = 1; mode = 3'(md); chan_sel = 0; level = 8'd128; pulse_len = 16'(lens[li]);
        for (int r = 1; r <= 7; r++) begin
          for (int k = 0; k < r; k++) begin
            step(1, md == 2 ? 8'd200 : 8'd50, 8'd128, 0, md == 2 ? "R6" : "R7");
            if (k % 2 == 1) step(0, md == 2 ? 8'd50 : 8'd200, 8'd128, 0, "R8");
          end
          step(1, (r % 2) ? 8'd128 : (md == 2 ? 8'd10 : 8'd240), 8'd0, 0, "R8");
          step(1, 8'd128, 8'd0, 0, "R8");
        end
      end

    // External edges, and external ignored in level mode
    for (int md = 4; md >= 0; md -= 4) begin
      do_reset();
      arm = 1; mode = 3'(md); level = 8'd128;
      for (int k = 0; k < 64; k++)
        step(k % 2 == 0, 8'd10, 8'd10, (k % 7) < 3 || k % 5 == 0, "R9");
    end

    // Arm toggling during a sweep
    do_reset();
    mode = 0; level = 8'd60; chan_sel = 0;
    for (int k = 0; k < 400; k++) begin
      arm = (k % 5) != 0 && (k % 11) != 3;
      step(1, 8'((k * 37) % 256), 8'd0, 0, "R10");
    end
    do_reset();
    mode = 2; level = 8'd60; pulse_len = 16'd3;
    for (int k = 0; k < 200; k++) begin
      arm = (k % 4) != 1;
      step(k % 6 != 0, 8'((k / 3) % 2 ? 200 : 10), 8'd0, 0, "R10");
    end

    // Unused mode codes
    for (int md = 5; md < 8; md++) begin
      do_reset();
      arm = 1; mode = 3'(md); level = 8'd100; pulse_len = 16'd1;
      for (int k = 0; k < 64; k++)
        step(1, 8'((k * 29) % 256), 8'((k * 53) % 256), k[1], "R11");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule